// File: doc/BRIEF.md
# DDR Mode-Register Bring-Up Sequencer

This block walks a DDR memory controller through its power-up programming. After a start pulse it issues a fixed list of register writes on a simple write port, which has an address, a data word and a valid/ready handshake. Each memory command is raised by first writing the mode or extended-mode value to its holding register. A write to the control register follows, carrying one set bit that selects the command. The block issues one of two lists. A type strap chooses the DDR2 list or the DDR1 list. A reference-clock strap chooses the refresh period that is written near the end of both lists.

The straps are captured on the start pulse. They may then change while the list runs with no effect. Only one write is outstanding at a time. The address and data of that write stay fixed until the controller accepts it. When the last write is accepted, done rises. Done stays high until the next start, and no further write is issued in that time.

Top module: `ddr_init_seq`

## Requirements
- R1: With ddr2 strap high, the writes are, as (register code, data): (9,0xFFFFF) (10,0xA59) (0,0x08) (3,0) (0,0x10) (4,0) (0,0x20) (2,0) (0,0x02) (1,0x100) (0,0x01) (0,0x08) (0,0x04) (0,0x04) (1,0xA33) (0,0x01) (2,0x382) (0,0x02) (2,0x402) (0,0x02) (5,refresh) (6,0x08) (7,0x09) (8,0xFF). Register codes: 0 control, 1 mode, 2 ext-mode 1, 3 ext-mode 2, 4 ext-mode 3, 5 refresh, 6 tap 0, 7 tap 1, 8 read-cycle, 9 timeout, 10 DDR2 config.
- R2: With ddr2 strap low, the writes are: (9,0xFFFFF) (0,0x08) (1,0x133) (0,0x01) (2,0x02) (0,0x02) (0,0x08) (1,0x33) (0,0x01) (5,refresh) (6,0x08) (7,0x09) (8,0xFF).
- R3: The refresh word has bit 14 set and the period in bits 9:0. The period is 624 (0x4270) when the 40 MHz strap is high and 390 (0x4186) when it is low.
- R4: Every write to the control register has exactly one of bits 5:0 set and all other bits clear. The command bits are: bit 0 mode set, bit 1 ext-mode 1 set, bit 2 auto-refresh, bit 3 precharge-all, bit 4 ext-mode 2 set, bit 5 ext-mode 3 set.
- R5: While valid is high and ready is low, valid, address and data hold their values into the next cycle.
- R6: The straps are sampled only on an accepted start. A strap change during a run does not alter the list.
- R7: Done rises only when the final write is accepted. It stays high with valid low until the next start. A start pulse during a run is ignored.
- R8: After reset, valid and done are low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken when idle or done |
| ddr2_strap_i | input | 1 | 1 selects the DDR2 list |
| clk40_strap_i | input | 1 | 1 selects the 40 MHz refresh period |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Controller accepts the write |
| wr_addr_o | output | 4 | Register code |
| wr_data_o | output | 32 | Register value |
| done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with its default values: the timeout, config, refresh periods and tap values all at their stated constants. This makes every word of both lists comparable against fixed bench tables. All four strap combinations are run, with random ready back-pressure. Strap toggles and stray start pulses during a run cover the capture and ignore rules. Runs that follow one another reach the restart from done.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int D2_STEPS = 24;
  localparam int D1_STEPS = 13;
  localparam int IDX_W = $clog2(D2_STEPS);

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 4'd0,
    REG_MODE    = 4'd1,
    REG_EXT1    = 4'd2,
    REG_EXT2    = 4'd3,
    REG_EXT3    = 4'd4,
    REG_REFRESH = 4'd5,
    REG_TAP0    = 4'd6,
    REG_TAP1    = 4'd7,
    REG_RDCYC   = 4'd8,
    REG_TIMEOUT = 4'd9,
    REG_D2CFG   = 4'd10
  } reg_sel_e;

  // command bit positions in the control word
  localparam int CB_MRS  = 0;
  localparam int CB_EMR1 = 1;
  localparam int CB_AREF = 2;
  localparam int CB_PRE  = 3;
  localparam int CB_EMR2 = 4;
  localparam int CB_EMR3 = 5;
  localparam int REF_EN_BIT = 14;
  localparam int REF_PER_W = 10;

  typedef struct packed {
    reg_sel_e          sel;
    logic [DATA_W-1:0] val;
    logic              last;
  } step_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_e;
endpackage

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
  import ddr_init_pkg::*;
#(
  parameter logic [DATA_W-1:0] TIMEOUT_VAL = 32'h000F_FFFF,
  parameter logic [DATA_W-1:0] D2CFG_VAL   = 32'h0000_0A59,
  parameter int                REF_PER_40  = 624,
  parameter int                REF_PER_25  = 390,
  parameter logic [DATA_W-1:0] TAP0_VAL    = 32'h08,
  parameter logic [DATA_W-1:0] TAP1_VAL    = 32'h09,
  parameter logic [DATA_W-1:0] RDCYC_VAL   = 32'hFF
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ddr2_i,
  input  logic             clk40_i,
  output step_t            step_o
);
  localparam logic [DATA_W-1:0] C_MRS  = DATA_W'(1) << CB_MRS;
  localparam logic [DATA_W-1:0] C_EMR1 = DATA_W'(1) << CB_EMR1;
  localparam logic [DATA_W-1:0] C_AREF = DATA_W'(1) << CB_AREF;
  localparam logic [DATA_W-1:0] C_PRE  = DATA_W'(1) << CB_PRE;
  localparam logic [DATA_W-1:0] C_EMR2 = DATA_W'(1) << CB_EMR2;
  localparam logic [DATA_W-1:0] C_EMR3 = DATA_W'(1) << CB_EMR3;
  localparam logic [REF_PER_W-1:0] PER40 = REF_PER_W'(REF_PER_40);
  localparam logic [REF_PER_W-1:0] PER25 = REF_PER_W'(REF_PER_25);

  logic [DATA_W-1:0] ref_word;
  always_comb begin
    ref_word = '0;
    ref_word[REF_EN_BIT] = 1'b1;
    ref_word[REF_PER_W-1:0] = clk40_i ? PER40 : PER25;
  end

  always_comb begin
    step_o = '{sel: REG_CTRL, val: '0, last: 1'b0};
    if (ddr2_i) begin
      unique case (idx_i)
        5'd0:  step_o = '{REG_TIMEOUT, TIMEOUT_VAL, 1'b0};
        5'd1:  step_o = '{REG_D2CFG, D2CFG_VAL, 1'b0};
        5'd2:  step_o = '{REG_CTRL, C_PRE, 1'b0};
        5'd3:  step_o = '{REG_EXT2, '0, 1'b0};
        5'd4:  step_o = '{REG_CTRL, C_EMR2, 1'b0};
        5'd5:  step_o = '{REG_EXT3, '0, 1'b0};
        5'd6:  step_o = '{REG_CTRL, C_EMR3, 1'b0};
        5'd7:  step_o = '{REG_EXT1, '0, 1'b0};
        5'd8:  step_o = '{REG_CTRL, C_EMR1, 1'b0};
        5'd9:  step_o = '{REG_MODE, 32'h100, 1'b0};
        5'd10: step_o = '{REG_CTRL, C_MRS, 1'b0};
        5'd11: step_o = '{REG_CTRL, C_PRE, 1'b0};
        5'd12: step_o = '{REG_CTRL, C_AREF, 1'b0};
        5'd13: step_o = '{REG_CTRL, C_AREF, 1'b0};
        5'd14: step_o = '{REG_MODE, 32'hA33, 1'b0};
        5'd15: step_o = '{REG_CTRL, C_MRS, 1'b0};
        5'd16: step_o = '{REG_EXT1, 32'h382, 1'b0};
        5'd17: step_o = '{REG_CTRL, C_EMR1, 1'b0};
        5'd18: step_o = '{REG_EXT1, 32'h402, 1'b0};
        5'd19: step_o = '{REG_CTRL, C_EMR1, 1'b0};
        5'd20: step_o = '{REG_REFRESH, ref_word, 1'b0};
        5'd21: step_o = '{REG_TAP0, TAP0_VAL, 1'b0};
        5'd22: step_o = '{REG_TAP1, TAP1_VAL, 1'b0};
        5'd23: step_o = '{REG_RDCYC, RDCYC_VAL, 1'b1};
        default: step_o = '{REG_CTRL, '0, 1'b1};
      endcase
    end else begin
      unique case (idx_i)
        5'd0:  step_o = '{REG_TIMEOUT, TIMEOUT_VAL, 1'b0};
        5'd1:  step_o = '{REG_CTRL, C_PRE, 1'b0};
        5'd2:  step_o = '{REG_MODE, 32'h133, 1'b0};
        5'd3:  step_o = '{REG_CTRL, C_MRS, 1'b0};
        5'd4:  step_o = '{REG_EXT1, 32'h02, 1'b0};
        5'd5:  step_o = '{REG_CTRL, C_EMR1, 1'b0};
        5'd6:  step_o = '{REG_CTRL, C_PRE, 1'b0};
        5'd7:  step_o = '{REG_MODE, 32'h33, 1'b0};
        5'd8:  step_o = '{REG_CTRL, C_MRS, 1'b0};
        5'd9:  step_o = '{REG_REFRESH, ref_word, 1'b0};
        5'd10: step_o = '{REG_TAP0, TAP0_VAL, 1'b0};
        5'd11: step_o = '{REG_TAP1, TAP1_VAL, 1'b0};
        5'd12: step_o = '{REG_RDCYC, RDCYC_VAL, 1'b1};
        default: step_o = '{REG_CTRL, '0, 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_wport.sv
module ddr_init_wport
  import ddr_init_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  step_t             step_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fire_o
);
  assign fire_o = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else if (issue_i) begin
      valid_o <= 1'b1;
      addr_o  <= step_i.sel;
      data_o  <= step_i.val;
    end else if (fire_o) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ddr2_strap_i,
  input  logic             clk40_strap_i,
  input  logic             pend_i,
  input  logic             fire_i,
  input  logic             last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             ddr2_o,
  output logic             clk40_o,
  output logic             issue_o,
  output logic             done_o
);
  seq_state_e state_q;

  assign issue_o = (state_q == ST_RUN) && !pend_i;
  assign done_o  = (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_o   <= '0;
      ddr2_o  <= 1'b0;
      clk40_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (fire_i) begin
            if (last_i) state_q <= ST_FIN;
            else        idx_o   <= idx_o + 1'b1;
          end
        end
        default: begin
          if (start_i) begin
            state_q <= ST_RUN;
            idx_o   <= '0;
            ddr2_o  <= ddr2_strap_i;
            clk40_o <= clk40_strap_i;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter logic [DATA_W-1:0] TIMEOUT_VAL = 32'h000F_FFFF,
  parameter logic [DATA_W-1:0] D2CFG_VAL   = 32'h0000_0A59,
  parameter int                REF_PER_40  = 624,
  parameter int                REF_PER_25  = 390,
  parameter logic [DATA_W-1:0] TAP0_VAL    = 32'h08,
  parameter logic [DATA_W-1:0] TAP1_VAL    = 32'h09,
  parameter logic [DATA_W-1:0] RDCYC_VAL   = 32'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ddr2_strap_i,
  input  logic              clk40_strap_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o
);
  logic [IDX_W-1:0] idx;
  logic ddr2_q, clk40_q, issue, fire;
  step_t step;

  ddr_init_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .ddr2_strap_i, .clk40_strap_i,
    .pend_i(wr_valid_o), .fire_i(fire), .last_i(step.last),
    .idx_o(idx), .ddr2_o(ddr2_q), .clk40_o(clk40_q),
    .issue_o(issue), .done_o(done_o)
  );

  ddr_init_steps #(
    .TIMEOUT_VAL(TIMEOUT_VAL), .D2CFG_VAL(D2CFG_VAL),
    .REF_PER_40(REF_PER_40), .REF_PER_25(REF_PER_25),
    .TAP0_VAL(TAP0_VAL), .TAP1_VAL(TAP1_VAL), .RDCYC_VAL(RDCYC_VAL)
  ) u_steps (
    .idx_i(idx), .ddr2_i(ddr2_q), .clk40_i(clk40_q), .step_o(step)
  );

  ddr_init_wport u_wport (
    .clk_i, .rst_ni, .issue_i(issue), .step_i(step),
    .ready_i(wr_ready_i), .valid_o(wr_valid_o),
    .addr_o(wr_addr_o), .data_o(wr_data_o), .fire_o(fire)
  );
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              done_o
);
  a_r4_ctrl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o == REG_CTRL) |->
      ($countones(wr_data_o[5:0]) == 1 && wr_data_o[DATA_W-1:6] == '0));

  a_r5_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  a_r7_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o);

  a_r7_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_valid_o && wr_ready_i && wr_addr_o == REG_RDCYC));

  a_r3_refresh_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o == REG_REFRESH) |-> wr_data_o[REF_EN_BIT]);

  always_comb begin
    if (!rst_ni) a_r8_reset_idle: assert (!wr_valid_o && !done_o);
  end
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .done_o(done_o)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, s_ddr2 = 1'b0, s_c40 = 1'b0, ready = 1'b0;
  logic valid, done;
  logic [3:0] addr;
  logic [31:0] data;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int ready_pct = 50;
  bit  stray = 1'b0;

  always #5 clk = ~clk;

  ddr_init_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ddr2_strap_i(s_ddr2), .clk40_strap_i(s_c40),
    .wr_valid_o(valid), .wr_ready_i(ready),
    .wr_addr_o(addr), .wr_data_o(data), .done_o(done)
  );

  logic [3:0]  log_a [0:31];
  logic [31:0] log_d [0:31];
  int log_n = 0;

  function automatic int exp_len(bit d2);
    return d2 ? 24 : 13;
  endfunction

  function automatic logic [35:0] exp_step(bit d2, bit c40, int i);
    logic [31:0] rw;
    rw = c40 ? 32'h4270 : 32'h4186;
    if (d2) begin
      case (i)
        0: return {4'd9, 32'hFFFFF};  1: return {4'd10, 32'hA59};
        2: return {4'd0, 32'h08};     3: return {4'd3, 32'h0};
        4: return {4'd0, 32'h10};     5: return {4'd4, 32'h0};
        6: return {4'd0, 32'h20};     7: return {4'd2, 32'h0};
        8: return {4'd0, 32'h02};     9: return {4'd1, 32'h100};
        10: return {4'd0, 32'h01};    11: return {4'd0, 32'h08};
        12: return {4'd0, 32'h04};    13: return {4'd0, 32'h04};
        14: return {4'd1, 32'hA33};   15: return {4'd0, 32'h01};
        16: return {4'd2, 32'h382};   17: return {4'd0, 32'h02};
        18: return {4'd2, 32'h402};   19: return {4'd0, 32'h02};
        20: return {4'd5, rw};        21: return {4'd6, 32'h08};
        22: return {4'd7, 32'h09};    default: return {4'd8, 32'hFF};
      endcase
    end else begin
      case (i)
        0: return {4'd9, 32'hFFFFF};  1: return {4'd0, 32'h08};
        2: return {4'd1, 32'h133};    3: return {4'd0, 32'h01};
        4: return {4'd2, 32'h02};     5: return {4'd0, 32'h02};
        6: return {4'd0, 32'h08};     7: return {4'd1, 32'h33};
        8: return {4'd0, 32'h01};     9: return {4'd5, rw};
        10: return {4'd6, 32'h08};    11: return {4'd7, 32'h09};
        default: return {4'd8, 32'hFF};
      endcase
    end
  endfunction

  task automatic check(bit ok, string req, string what, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive ready and log handshakes at the falling edge
  always @(negedge clk) begin
    cyc++;
    ready = ($urandom % 100) < ready_pct;
    if (valid && ready && log_n < 32) begin
      log_a[log_n] = addr;
      log_d[log_n] = data;
      log_n++;
    end
  end

  task automatic run_one(bit d2, bit c40);
    int t;
    logic [35:0] e;
    string rq;
    rq = d2 ? "R1" : "R2";
    @(negedge clk);
    s_ddr2 = d2; s_c40 = c40; start = 1'b1;
    log_n = 0;
    @(negedge clk);
    start = 1'b0;
    if (stray) begin
      // R6: strap flips and R7: stray start, both during the run
      repeat (4) @(negedge clk);
      s_ddr2 = ~d2; s_c40 = ~c40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(done, "R7", "done after run", {35'd0, done}, 36'd1);
    check(log_n == exp_len(d2), stray ? "R6" : rq, "write count",
          36'(log_n), 36'(exp_len(d2)));
    for (int i = 0; i < exp_len(d2) && i < log_n; i++) begin
      e = exp_step(d2, c40, i);
      check({log_a[i], log_d[i]} == e, (i == (d2 ? 20 : 9)) ? "R3" : rq,
            "write", {log_a[i], log_d[i]}, e);
    end
    // R7: quiet while done, no writes appear
    repeat (6) @(negedge clk);
    check(done && !valid && log_n == exp_len(d2), "R7", "done holds, no writes",
          {34'd0, done, valid}, 36'd2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(!valid && !done, "R8", "reset outputs", {34'd0, valid, done}, 36'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!valid && !done, "R8", "idle after reset", {34'd0, valid, done}, 36'd0);
    // directed: every strap pair, full and zero back-pressure
    ready_pct = 100; run_one(1'b1, 1'b1);
    ready_pct = 100; run_one(1'b0, 1'b0);
    ready_pct = 20;  run_one(1'b1, 1'b0);
    ready_pct = 20;  run_one(1'b0, 1'b1);
    stray = 1'b1;
    ready_pct = 30;  run_one(1'b1, 1'b0);
    ready_pct = 30;  run_one(1'b0, 1'b1);
    // random runs
    for (int k = 0; k < 8; k++) begin
      stray = $urandom % 2;
      ready_pct = 10 + $urandom % 91;
      run_one($urandom % 2, $urandom % 2);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R7: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule